// File: doc/BRIEF.md
# Frequency and Period Measurement Counter

This block measures a signal with one saturating counter, 20 bits wide by default. It has two ways to measure. In frequency mode it counts rising input edges during a gate window. The window lasts 1, 4, 8 or 32 timebase periods of one millisecond each, and it opens on a timebase tick. In period mode it counts ticks of a fixed reference clock from one rising edge of the input to the next.

There are two measurement inputs. The high-frequency input is halved before its edges reach the counter. The low-frequency input is counted directly and is the only input that period mode uses. Both inputs are asynchronous. Each one is synchronised to the system clock before its edges are detected.

A host first writes the configuration, which holds the mode, the channel and the gate code. It then pulses `start`. After that it either polls `busy` and `done` or watches them. When `done` is high, `result` and `overflow` hold the measurement.

Top module: `universal_counter`

## Requirements
- R1: After reset the outputs are as follows: `busy`, `done` and `overflow` are 0 and `result` is 0. The configuration is high-frequency channel, frequency mode and gate code 0. A start given without any configuration write runs exactly that measurement.
- R2: A pulse on `cfg_we` while the block is idle loads the three configuration fields. The fields are `cfg_period` (1 = period mode), `cfg_lf` (1 = low-frequency channel) and `cfg_gate`. A pulse on `cfg_we` while `busy` is high is ignored. Later measurements still use the old fields.
- R3: `start` is accepted in any state, including in the middle of a measurement. On the next cycle `result` is 0, `overflow` is 0, `done` is 0 and `busy` is 1.
- R4: The gate code selects the window length: code 0 gives 1 tick, code 1 gives 4, code 2 gives 8 and code 3 gives 32, with one tick per millisecond. In frequency mode the window opens on the first timebase tick after start. Events are counted from the cycle after that opening tick up to and including the cycle of the closing tick.
- R5: On the high-frequency channel, the 1st, 3rd, 5th and later odd-numbered rising edges inside the window are counted. The result is therefore half the edge count, rounded up. The halving phase is reset by each start.
- R6: On the low-frequency channel in frequency mode, every rising edge inside the window is counted.
- R7: Period mode always measures the low-frequency input, whatever `cfg_lf` holds. Counting starts after the first rising edge that follows start. Reference ticks are then counted up to and including the cycle of the next rising edge.
- R8: The counter stops at all ones and does not wrap. `overflow` becomes 1 when a count is lost and stays 1 until the next start.
- R9: An input edge is seen by the counter two clock edges after the input is sampled, through a two-stage synchroniser. Pulses of at least one clock period high and one low are counted.
- R10: When a measurement ends, `busy` falls and `done` rises in the same cycle. `done` and `result` then hold until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| hf_in | input | 1 | High-frequency measurement input (asynchronous) |
| lf_in | input | 1 | Low-frequency measurement input (asynchronous) |
| cfg_we | input | 1 | Configuration write strobe (honoured only when idle) |
| cfg_period | input | 1 | 1 = period mode, 0 = frequency mode |
| cfg_lf | input | 1 | 1 = low-frequency channel, 0 = high-frequency channel |
| cfg_gate | input | 2 | Gate code: 0, 1, 2, 3 give 1, 4, 8, 32 ticks |
| start | input | 1 | Clears the result and begins a measurement |
| busy | output | 1 | Measurement in progress |
| done | output | 1 | Last measurement finished; held until the next start |
| overflow | output | 1 | Counter saturated during the measurement |
| result | output | CNT_W | Measurement count |

## Verification
A wrong window phase, or a wrong halving phase, changes `result` by one or more counts. The bench model catches this on the first cycle after the wrong event, because `result` updates while the measurement runs. A controller that is stuck or runs too long shows at once as a mismatch on `busy` or `done`. A counter that wraps shows as `result` dropping while `overflow` stays low. A configuration write that leaks in while busy only shows on the next measurement, as a mode or window different from the model's.

// File: rtl/uc_pkg.sv
package uc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_ARM   = 3'd1,
    ST_GATE  = 3'd2,
    ST_PWAIT = 3'd3,
    ST_PRUN  = 3'd4
  } uc_state_e;

  localparam int LEFT_W = 6;

  function automatic logic [LEFT_W-1:0] gate_ticks(input logic [1:0] code);
    case (code)
      2'd0:    return LEFT_W'(1);
      2'd1:    return LEFT_W'(4);
      2'd2:    return LEFT_W'(8);
      default: return LEFT_W'(32);
    endcase
  endfunction
endpackage

// File: rtl/uc_sync_edge.sv
module uc_sync_edge #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] din,
  output logic [N-1:0] rise
);
  for (genvar i = 0; i < N; i++) begin : g_ch
    logic s1_q, s2_q, prev_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        s1_q   <= 1'b0;
        s2_q   <= 1'b0;
        prev_q <= 1'b0;
      end else begin
        s1_q   <= din[i];
        s2_q   <= s1_q;
        prev_q <= s2_q;
      end
    end
    assign rise[i] = s2_q & ~prev_q;

    // R9: a detected edge is a single-cycle pulse
    a_r9_single_pulse: assert property (@(posedge clk) disable iff (rst)
      rise[i] |=> !rise[i]);
  end
endmodule

// File: rtl/uc_prescaler.sv
module uc_prescaler #(
  parameter int DIV = 50000
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int W = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [W-1:0] LAST = W'(DIV - 1);

  logic [W-1:0] cnt_q;

  assign tick = (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (rst || tick) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/uc_sat_counter.sv
module uc_sat_counter #(
  parameter int W = 20
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] q,
  output logic         ovf
);
  localparam logic [W-1:0] FULL = {W{1'b1}};

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      q   <= '0;
      ovf <= 1'b0;
    end else if (inc) begin
      if (q == FULL) ovf <= 1'b1;
      else           q   <= q + 1'b1;
    end
  end

  // R8: a count at full scale keeps the value and raises overflow
  a_r8_saturate: assert property (@(posedge clk) disable iff (rst)
    (inc && !clr && q == FULL) |=> (q == FULL && ovf));

  // R8: without a clear the count never goes down
  a_r8_no_wrap: assert property (@(posedge clk) disable iff (rst)
    !clr |=> (q >= $past(q)));
endmodule

// File: rtl/universal_counter.sv
module universal_counter
  import uc_pkg::*;
#(
  parameter int CNT_W    = 20,
  parameter int TICK_CYC = 50000,
  parameter int REF_CYC  = 50
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hf_in,
  input  logic             lf_in,
  input  logic             cfg_we,
  input  logic             cfg_period,
  input  logic             cfg_lf,
  input  logic [1:0]       cfg_gate,
  input  logic             start,
  output logic             busy,
  output logic             done,
  output logic             overflow,
  output logic [CNT_W-1:0] result
);
  logic [1:0] rise_v;
  logic       hf_rise, lf_rise, ms_tick, ref_tick;

  uc_sync_edge #(.N(2)) sync_i (
    .clk(clk), .rst(rst), .din({lf_in, hf_in}), .rise(rise_v)
  );
  assign hf_rise = rise_v[0];
  assign lf_rise = rise_v[1];

  uc_prescaler #(.DIV(TICK_CYC)) ms_i  (.clk(clk), .rst(rst), .tick(ms_tick));
  uc_prescaler #(.DIV(REF_CYC))  ref_i (.clk(clk), .rst(rst), .tick(ref_tick));

  uc_state_e         state_q;
  logic              per_q, lf_q, half_q, done_q;
  logic [1:0]        gate_q;
  logic [LEFT_W-1:0] left_q;
  logic              event_c, cnt_inc;

  assign event_c = lf_q ? lf_rise : (hf_rise & ~half_q);
  assign cnt_inc = !start &&
                   ((state_q == ST_GATE && event_c) || (state_q == ST_PRUN && ref_tick));

  uc_sat_counter #(.W(CNT_W)) cnt_i (
    .clk(clk), .rst(rst), .clr(start), .inc(cnt_inc), .q(result), .ovf(overflow)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      per_q   <= 1'b0;
      lf_q    <= 1'b0;
      gate_q  <= 2'd0;
      left_q  <= '0;
      half_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      if (cfg_we && state_q == ST_IDLE) begin
        per_q  <= cfg_period;
        lf_q   <= cfg_lf;
        gate_q <= cfg_gate;
      end
      if (start) begin
        state_q <= per_q ? ST_PWAIT : ST_ARM;
        left_q  <= gate_ticks(gate_q);
        half_q  <= 1'b0;
        done_q  <= 1'b0;
      end else begin
        case (state_q)
          ST_ARM:   if (ms_tick) state_q <= ST_GATE;
          ST_GATE: begin
            if (hf_rise) half_q <= ~half_q;
            if (ms_tick) begin
              if (left_q == LEFT_W'(1)) begin
                state_q <= ST_IDLE;
                done_q  <= 1'b1;
              end else begin
                left_q <= left_q - 1'b1;
              end
            end
          end
          ST_PWAIT: if (lf_rise) state_q <= ST_PRUN;
          ST_PRUN: if (lf_rise) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b1;
          end
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end

  assign busy = (state_q != ST_IDLE);
  assign done = done_q;

  // R10: done is never shown together with busy
  a_r10_done_idle: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  // R2: configuration stays unchanged while a measurement runs
  a_r2_cfg_frozen: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable({per_q, lf_q, gate_q}));

  // R3: start clears the result and flags and makes the block busy
  a_r3_start_clears: assert property (@(posedge clk) disable iff (rst)
    start |=> (result == '0 && !overflow && !done && busy));

  // R4: the window stays closed until a timebase tick
  a_r4_arm_waits: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_ARM && !ms_tick && !start) |=> (state_q == ST_ARM && result == '0));

  // R7: in period mode the count advances only while the input period is being timed
  a_r7_wait_no_count: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_PWAIT && !start) |=> $stable(result));
endmodule

// File: tb/universal_counter_tb_top.sv
module universal_counter_tb_top;
  localparam int CW = 8;
  localparam int T  = 16;
  localparam int R  = 2;
  localparam int MAXV = (1 << CW) - 1;

  logic clk = 1'b0, rst = 1'b1;
  logic hf_in = 1'b0, lf_in = 1'b0, cfg_we = 1'b0, cfg_period = 1'b0, cfg_lf = 1'b0, start = 1'b0;
  logic [1:0] cfg_gate = 2'd0;
  logic busy, done, overflow;
  logic [CW-1:0] result;

  always #4 clk = ~clk;

  universal_counter #(.CNT_W(CW), .TICK_CYC(T), .REF_CYC(R)) dut_i (
    .clk(clk), .rst(rst), .hf_in(hf_in), .lf_in(lf_in), .cfg_we(cfg_we),
    .cfg_period(cfg_period), .cfg_lf(cfg_lf), .cfg_gate(cfg_gate), .start(start),
    .busy(busy), .done(done), .overflow(overflow), .result(result)
  );

  int tests = 0, fails = 0, cyc = 0;
  string cur_req = "R1";
  bit cmp_on = 0;

  // stimulus waveforms: half periods in cycles, 0 = hold low
  int hf_half = 0, lf_half = 0, hf_ctr = 0, lf_ctr = 0;
  always @(negedge clk) begin
    if (hf_half == 0) hf_in <= 1'b0;
    else if (++hf_ctr >= hf_half) begin hf_ctr = 0; hf_in <= ~hf_in; end
    if (lf_half == 0) lf_in <= 1'b0;
    else if (++lf_ctr >= lf_half) begin lf_ctr = 0; lf_in <= ~lf_in; end
  end

  // behavioural reference model: 0 idle, 1 wait tick, 2 gate, 3 wait edge, 4 timing
  int m_st, m_cnt, m_left, m_k;
  bit m_ovf, m_done, m_half, m_per, m_lf;
  int m_gate;
  bit [2:0] hh, lh;
  always @(posedge clk) begin
    if (rst) begin
      m_st = 0; m_cnt = 0; m_left = 0; m_k = 0; m_ovf = 0; m_done = 0; m_half = 0;
      m_per = 0; m_lf = 0; m_gate = 0; hh = 0; lh = 0;
    end else begin
      bit hr, lr, mt, rt, ev, inc, o_per;
      int o_st, o_gate;
      hr = hh[1] && !hh[2];
      lr = lh[1] && !lh[2];
      mt = (m_k % T) == T - 1;
      rt = (m_k % R) == R - 1;
      o_st = m_st; o_per = m_per; o_gate = m_gate;
      ev = m_lf ? lr : (hr && !m_half);
      inc = !start && ((o_st == 2 && ev) || (o_st == 4 && rt));
      if (cfg_we && o_st == 0) begin m_per = cfg_period; m_lf = cfg_lf; m_gate = cfg_gate; end
      if (start) begin
        m_cnt = 0; m_ovf = 0; m_done = 0; m_half = 0;
        m_st = o_per ? 3 : 1;
        m_left = (o_gate == 0) ? 1 : (o_gate == 1) ? 4 : (o_gate == 2) ? 8 : 32;
      end else begin
        if (inc) begin if (m_cnt == MAXV) m_ovf = 1; else m_cnt++; end
        case (o_st)
          1: if (mt) m_st = 2;
          2: begin
            if (hr) m_half = !m_half;
            if (mt) begin
              if (m_left == 1) begin m_st = 0; m_done = 1; end else m_left--;
            end
          end
          3: if (lr) m_st = 4;
          4: if (lr) begin m_st = 0; m_done = 1; end
          default: ;
        endcase
      end
      hh = {hh[1:0], hf_in};
      lh = {lh[1:0], lf_in};
      m_k++;
    end
  end

  // per-cycle comparison (R9 timing is covered by exact cycle matching)
  always @(negedge clk) begin
    cyc++;
    if (cmp_on) begin
      tests++;
      if (busy !== (m_st != 0) || done !== m_done || overflow !== m_ovf || result !== CW'(m_cnt)) begin
        fails++;
        $display("FAIL %s R9 cycle %0d: busy/done/ovf/result = %0b/%0b/%0b/%0d expected %0b/%0b/%0b/%0d",
                 cur_req, cyc, busy, done, overflow, result, m_st != 0, m_done, m_ovf, m_cnt);
      end
    end
  end

  task automatic check(input string req, input bit ok, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic write_cfg(input bit per, input bit lf, input int gate);
    @(negedge clk);
    cfg_we = 1; cfg_period = per; cfg_lf = lf; cfg_gate = 2'(gate);
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic pulse_start();
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
  endtask

  task automatic wait_done();
    for (int i = 0; i < 5000 && !done; i++) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check("R1 busy", busy == 0, busy, 0);
    check("R1 done", done == 0, done, 0);
    check("R1 overflow", overflow == 0, overflow, 0);
    check("R1 result", result == 0, result, 0);
    cmp_on = 1;

    // default configuration: high channel, frequency, one tick
    cur_req = "R1"; hf_half = 1;
    pulse_start();
    check("R3 busy after start", busy == 1, busy, 1);
    wait_done();
    check("R1 default window result", result >= 3 && result <= 5, result, 4);

    // low channel, frequency, four ticks: 64 cycles, rise every 4
    cur_req = "R6"; hf_half = 0; lf_half = 2;
    write_cfg(0, 1, 1);
    pulse_start(); wait_done();
    check("R6 low channel count", result >= 15 && result <= 17, result, 16);
    check("R10 done held", done == 1 && busy == 0, done, 1);
    repeat (20) @(negedge clk);
    check("R10 done still held", done == 1, done, 1);

    // high channel halved, eight ticks: 128 cycles, 64 rises
    cur_req = "R5"; lf_half = 0; hf_half = 1;
    write_cfg(0, 0, 2);
    pulse_start(); wait_done();
    check("R5 halved count", result >= 31 && result <= 33, result, 32);

    // 32-tick gate: 512 cycles, 256 rises, 128 counts
    cur_req = "R4";
    write_cfg(0, 0, 3);
    pulse_start(); wait_done();
    check("R4 long window", result >= 127 && result <= 129, result, 128);

    // period mode with channel bit on the high input: low input still measured
    cur_req = "R7"; lf_half = 10;
    write_cfg(1, 0, 0);
    pulse_start();
    repeat (10) @(negedge clk);
    cfg_we = 1; cfg_period = 0; cfg_lf = 1; cfg_gate = 2'd0;   // ignored while busy
    @(negedge clk); cfg_we = 0;
    wait_done();
    check("R7 period count", result == 10, result, 10);

    cur_req = "R2";
    pulse_start(); wait_done();
    check("R2 write while busy ignored", result == 10, result, 10);

    // saturation: long period
    cur_req = "R8"; hf_half = 0; lf_half = 600;
    pulse_start(); wait_done();
    check("R8 saturated result", result == MAXV, result, MAXV);
    check("R8 overflow flag", overflow == 1, overflow, 1);

    // restart in mid measurement
    cur_req = "R3"; lf_half = 2;
    write_cfg(0, 1, 1);
    pulse_start();
    repeat (40) @(negedge clk);
    pulse_start();
    check("R3 restart clears result", result == 0, result, 0);
    check("R3 restart flags", busy == 1 && done == 0 && overflow == 0, busy, 1);
    wait_done();
    check("R3 restarted run finishes", done == 1, done, 1);

    repeat (5) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    wait (cyc > 100000);
    fails++;
    $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule